// File: doc/BRIEF.md
# Multichannel ADC Averaging Limit Checker

This block is the digital back end of a round-robin 12-bit converter. A start pulse launches a sweep over the channels whose bits are set in an enable mask. Up to twelve channels, supply voltages and temperatures alike, are converted in ascending index order, and disabled indices cost no cycle. The converter is reached through a request/done/data handshake. Each enabled channel gets one conversion, or sixteen when averaging is selected for that sweep. In averaging mode the sixteen samples are summed in a 16-bit accumulator and the sum is shifted right by four.

Each finished channel result goes into a readback register, which is selected through a read index. The result is compared with that channel's limit. A per-channel mode bit makes the limit either a ceiling or a floor. A violation sets a sticky fault bit, which stays set until software writes a one to it. A one-cycle done pulse marks the end of the sweep.

Top module: `adc_avg_limit`

## Requirements
- R1: After reset, `adc_start`, `busy`, `sweep_done` and every `lim_flag` bit are 0, and every readback register reads 0.
- R2: A sweep converts exactly the channels set in the mask, lowest index first. Each conversion request carries its channel index on `adc_ch`. Disabled channels get no request.
- R3: With averaging off, a channel's readback register takes the single converted sample.
- R4: With averaging on, a channel gets 16 consecutive requests. Its readback register takes bits [15:4] of the 16-bit sum of those samples.
- R5: When `lim_is_min` bit n is 0, channel n faults if its new result is greater than its limit. When the bit is 1, it faults if the result is less than its limit. A result equal to the limit never faults.
- R6: A fault bit stays set through later fault-free sweeps. Writing 1 to its `flag_clr` bit clears it on the next edge, and bits written 0 are untouched.
- R7: `sweep_done` is high for exactly one cycle. That cycle immediately follows the edge that stores the sweep's last result. With an empty mask it follows the start edge, and no conversion is requested.
- R8: `sweep_start` is ignored while `busy` is high. `ch_en` and `avg_en` are sampled only at the accepted start.
- R9: A channel left out of a sweep keeps its previous readback value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_start | input | 1 | Start-of-sweep pulse |
| avg_en | input | 1 | 1 = sixteen-sample averaging for this sweep |
| ch_en | input | NCH | Channel enable mask |
| lim_val | input | NCH*DW | Per-channel limits, channel n at bits [n*DW +: DW] |
| lim_is_min | input | NCH | Per-channel limit mode: 1 = floor, 0 = ceiling |
| flag_clr | input | NCH | Write-one-to-clear strobes for the fault bits |
| adc_start | output | 1 | Conversion request, one cycle |
| adc_ch | output | CW | Channel of the current request |
| adc_done | input | 1 | Conversion finished, data valid |
| adc_data | input | DW | Conversion sample |
| rd_sel | input | CW | Readback channel select |
| rd_data | output | DW | Selected readback register |
| lim_flag | output | NCH | Sticky fault bits |
| sweep_done | output | 1 | End-of-sweep pulse |
| busy | output | 1 | Sweep in progress |

## Verification
A wrong channel pointer shows up on `adc_ch` at the very next request, as a wrong or missing entry in the conversion order. A miscounted sample counter changes the number of requests per channel. It also shifts the averaged value held in the readback register, which can be read at the `sweep_done` pulse. A bad accumulator or comparator leaves its trace on the readback value and on the fault bits in that same cycle. A fault bit that fails to hold shows up in the next sweep, whose limits cannot trip.

// File: rtl/adc_avg_limit.sv
module adc_avg_limit #(
  parameter int NCH      = 12,
  parameter int DW       = 12,
  parameter int AVG_LOG2 = 4,
  localparam int CW      = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW      = DW + AVG_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sweep_start,
  input  logic              avg_en,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH*DW-1:0] lim_val,
  input  logic [NCH-1:0]    lim_is_min,
  input  logic [NCH-1:0]    flag_clr,
  output logic              adc_start,
  output logic [CW-1:0]     adc_ch,
  input  logic              adc_done,
  input  logic [DW-1:0]     adc_data,
  input  logic [CW-1:0]     rd_sel,
  output logic [DW-1:0]     rd_data,
  output logic [NCH-1:0]    lim_flag,
  output logic              sweep_done,
  output logic              busy
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t              state;
  logic [NCH-1:0]      mask_q;
  logic                avg_q;
  logic [CW-1:0]       cur;
  logic [AW-1:0]       acc;
  logic [AVG_LOG2-1:0] cnt;
  logic [DW-1:0]       res [NCH];

  logic [CW-1:0]       fst_ch, nxt_ch;
  logic                nxt_found;
  logic [AW-1:0]       sum;
  logic [DW-1:0]       result, cur_lim;
  logic                last, wr, viol;
  logic [NCH-1:0]      set_v;

  always_comb begin
    fst_ch = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (ch_en[i]) fst_ch = CW'(i);
  end

  always_comb begin
    nxt_ch    = '0;
    nxt_found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--)
      if (mask_q[i] && i > int'(cur)) begin
        nxt_ch    = CW'(i);
        nxt_found = 1'b1;
      end
  end

  assign sum     = acc + AW'(adc_data);
  assign result  = avg_q ? sum[AW-1:AVG_LOG2] : adc_data;
  assign last    = !avg_q || (cnt == '1);
  assign wr      = (state == S_WAIT) && adc_done && last;
  assign cur_lim = lim_val[int'(cur)*DW +: DW];
  assign viol    = lim_is_min[cur] ? (result < cur_lim) : (result > cur_lim);
  assign set_v   = (wr && viol) ? (NCH'(1) << cur) : '0;

  assign adc_start = (state == S_REQ);
  assign adc_ch    = cur;
  assign busy      = (state != S_IDLE);
  assign rd_data   = (int'(rd_sel) < NCH) ? res[rd_sel] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      mask_q     <= '0;
      avg_q      <= 1'b0;
      cur        <= '0;
      acc        <= '0;
      cnt        <= '0;
      lim_flag   <= '0;
      sweep_done <= 1'b0;
      for (int i = 0; i < NCH; i++) res[i] <= '0;
    end else begin
      sweep_done <= 1'b0;
      lim_flag   <= (lim_flag & ~flag_clr) | set_v;
      case (state)
        S_IDLE:
          if (sweep_start) begin
            if (|ch_en) begin
              mask_q <= ch_en;
              avg_q  <= avg_en;
              cur    <= fst_ch;
              acc    <= '0;
              cnt    <= '0;
              state  <= S_REQ;
            end else begin
              sweep_done <= 1'b1;
            end
          end
        S_REQ:
          state <= S_WAIT;
        S_WAIT:
          if (adc_done) begin
            if (last) begin
              res[cur] <= result;
              acc      <= '0;
              cnt      <= '0;
              if (nxt_found) begin
                cur   <= nxt_ch;
                state <= S_REQ;
              end else begin
                state      <= S_IDLE;
                sweep_done <= 1'b1;
              end
            end else begin
              acc   <= sum;
              cnt   <= cnt + 1'b1;
              state <= S_REQ;
            end
          end
        default:
          state <= S_IDLE;
      endcase
    end
  end

endmodule

module adc_avg_limit_chk #(
  parameter int NCH = 12,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           adc_start,
  input logic [CW-1:0]  adc_ch,
  input logic           busy,
  input logic           sweep_done,
  input logic [NCH-1:0] lim_flag,
  input logic [NCH-1:0] flag_clr,
  input logic [NCH-1:0] mask_q
);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R2

  AST_REQ_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (int'(adc_ch) < NCH) && mask_q[adc_ch]); // R2

  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> !sweep_done); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(lim_flag) & ~$past(flag_clr)) & ~lim_flag) == '0)); // R6

endmodule

bind adc_avg_limit adc_avg_limit_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_ch(adc_ch),
  .busy(busy), .sweep_done(sweep_done), .lim_flag(lim_flag),
  .flag_clr(flag_clr), .mask_q(mask_q)
);

// File: tb/sim_adc_avg_limit.sv
module sim_adc_avg_limit;
  localparam int NCH = 12;
  localparam int DW  = 12;
  localparam int CW  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sweep_start = 1'b0;
  logic              avg_en = 1'b0;
  logic [NCH-1:0]    ch_en = '0;
  logic [NCH*DW-1:0] lim_val = '0;
  logic [NCH-1:0]    lim_is_min = '0;
  logic [NCH-1:0]    flag_clr = '0;
  logic              adc_start;
  logic [CW-1:0]     adc_ch;
  logic              adc_done = 1'b0;
  logic [DW-1:0]     adc_data = '0;
  logic [CW-1:0]     rd_sel = '0;
  logic [DW-1:0]     rd_data;
  logic [NCH-1:0]    lim_flag;
  logic              sweep_done;
  logic              busy;

  adc_avg_limit u0 (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int nconv = 0;
  int order [256];
  int samp [NCH];
  int pass_id = 0;
  bit pend = 0;
  int lat = 0;
  int pch = 0;
  int exp_res [NCH];
  logic [NCH-1:0] exp_flag = '0;

  function automatic int datf(int ch, int k, int p);
    return (ch * 331 + k * k * 13 + p * 977 + 5) % 4096;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    adc_done = 1'b0;
    if (pend) begin
      if (lat == 0) begin
        adc_done = 1'b1;
        adc_data = DW'(datf(pch, samp[pch], pass_id));
        samp[pch]++;
        pend = 0;
      end else lat--;
    end else if (adc_start) begin
      pend = 1;
      lat = 2;
      pch = int'(adc_ch);
      if (nconv < 256) order[nconv] = pch;
      nconv++;
    end
  end

  task automatic clear_all();
    @(negedge clk); flag_clr = '1;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!sweep_done && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic run_sweep(input logic [NCH-1:0] m, input bit av, input int p, input bit no_viol);
    int n = av ? 16 : 1;
    int idx = 0;
    pass_id = p;
    for (int c = 0; c < NCH; c++) begin
      samp[c] = 0;
      if (m[c]) begin
        int s = 0;
        for (int k = 0; k < n; k++) s += datf(c, k, p);
        exp_res[c] = av ? (s % 65536) / 16 : s;
        if (no_viol) begin
          lim_val[c*DW +: DW] = 12'hFFF;
          lim_is_min[c] = 1'b0;
        end else begin
          int l = exp_res[c] + (c % 3) - 1;
          if (l < 0) l = 0;
          if (l > 4095) l = 4095;
          lim_val[c*DW +: DW] = DW'(l);
          lim_is_min[c] = ((p + c) % 2) == 1;
          if (lim_is_min[c] ? (exp_res[c] < l) : (exp_res[c] > l)) exp_flag[c] = 1'b1;
        end
      end
    end
    nconv = 0;
    @(negedge clk); ch_en = m; avg_en = av; sweep_start = 1'b1;
    @(negedge clk); sweep_start = 1'b0; ch_en = ~m; avg_en = ~av;
    @(negedge clk); @(negedge clk); sweep_start = 1'b1;   // R8 ignored while busy
    chk(busy === 1'b1, "R8 busy", busy, 1);
    @(negedge clk); sweep_start = 1'b0;
    wait_done();
    chk(sweep_done === 1'b1, "R7 sweep_done", sweep_done, 1);
    chk(nconv == $countones(m) * n, "R2 R4 conversion count", nconv, $countones(m) * n);
    idx = 0;
    for (int c = 0; c < NCH; c++)
      if (m[c])
        for (int k = 0; k < n; k++) begin
          if (idx < 256 && order[idx] != c)
            chk(0, "R2 order", order[idx], c);
          idx++;
        end
    for (int c = 0; c < NCH; c++) begin
      rd_sel = CW'(c);
      #1;
      chk(rd_data == DW'(exp_res[c]), av ? "R4 R9 readback" : "R3 R9 readback",
          int'(rd_data), exp_res[c]);
    end
    chk(lim_flag == exp_flag, "R5 R6 flags", int'(lim_flag), int'(exp_flag));
    @(negedge clk);
    chk(sweep_done === 1'b0 && busy === 1'b0, "R7 pulse width", sweep_done, 0);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) exp_res[c] = 0;
    repeat (3) @(negedge clk);
    chk(adc_start === 1'b0 && busy === 1'b0 && sweep_done === 1'b0, "R1 control", busy, 0);
    chk(lim_flag === '0, "R1 flags", int'(lim_flag), 0);
    for (int c = 0; c < NCH; c++) begin
      rd_sel = CW'(c); #1;
      chk(rd_data === '0, "R1 readback", int'(rd_data), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    begin
      logic [NCH-1:0] masks [5] = '{12'hFFF, 12'hA65, 12'h001, 12'h800, 12'h5A3};
      int p = 1;
      for (int a = 0; a < 2; a++)
        for (int i = 0; i < 5; i++) begin
          clear_all();
          exp_flag = '0;
          chk(lim_flag == '0, "R6 clear", int'(lim_flag), 0);
          run_sweep(masks[i], a[0], p, 1'b0);
          p++;
        end

      run_sweep(12'hFFF, 1'b0, p, 1'b1);   // R6 sticky through fault-free sweep
      p++;
      @(negedge clk); flag_clr = 12'h0F0;
      @(negedge clk); flag_clr = '0;
      exp_flag = exp_flag & ~12'h0F0;
      chk(lim_flag == exp_flag, "R6 partial clear", int'(lim_flag), int'(exp_flag));
    end

    nconv = 0;
    @(negedge clk); ch_en = '0; sweep_start = 1'b1;
    @(negedge clk); sweep_start = 1'b0;
    chk(sweep_done === 1'b1, "R7 empty mask pulse", sweep_done, 1);
    @(negedge clk);
    chk(sweep_done === 1'b0 && nconv == 0, "R7 empty mask no conversion", nconv, 0);

    finish_run();
  end
endmodule